// File: doc/BRIEF.md
# Banked Fuse Read Controller

This block is a small memory-mapped controller for a 128-byte one-time-programmable fuse array. The array is split into eight banks, and each bank holds four 32-bit words. One read command fetches a whole bank. Software first picks a bank by writing a bit address, which is the bank index times 128. It then sets the read command bit, polls the completion flag, and reads the four captured words from a data window. Within a word, byte k is taken from bits 8k+7:8k.

During a read the controller holds the fuse-array read strobe high for a number of clock cycles that software programs. At the end it latches the bank contents and raises the completion flag. The command bit clears itself at the same moment. Several further control bits are stored for software and read back, but they do nothing here. These are backup-key2 select (bit 5), trim enable (bit 4), backup-key select (bit 3), secure-load (bit 1) and CRC (bit 0).

Top module: `otp_bank_reader`

## Requirements
- R1: After reset the strobe is low. The control register reads 0x0000_1E00, meaning a read period of 30 and all other bits zero. The status, address and all four window words read 0.
- R2: The register offsets are fixed. Control is at 0x48, with start at bit 2 and the period in bits 15:8. Status is at 0x4C, with done at bit 4. The bank bit address is at 0x50. Window word n is at 0x20+4n. Any other offset reads 0.
- R3: A control write with bit 2 set, made while idle, raises the strobe from the next cycle. The strobe stays high for exactly the number of cycles in the period field written by that same write. The bank output stays at the selected bank for the whole read.
- R4: When the strobe falls, window word n holds bits 32n+31:32n of the bank's fuse data, and status bit 4 reads 1. Control bit 2 reads 1 while the strobe is high and 0 afterwards.
- R5: Only bits 9:7 of a write to the address register take effect. That field is the bank index. The register reads back as the bank index times 128.
- R6: While a read is in progress, a control write has no effect. The strobe count, the stored period and the bank are unchanged. The window keeps its previous contents until the new capture.
- R7: Writing status with bit 4 at 0 clears the done flag. Writing it with bit 4 at 1 does not set the flag.
- R8: A period field of 0 gives a strobe exactly one cycle long.
- R9: Control bits 5, 4, 3, 1 and 0 read back as written. Writing them without bit 2 starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fuse_rd | output | 1 | Fuse-array read strobe |
| fuse_bank | output | 3 | Bank being read |
| fuse_data | input | 128 | Fuse contents of the bank on fuse_bank |
| rd_done | output | 1 | Completion flag, mirrors status bit 4 |

## Verification
Some properties are checked on every cycle by the assertions:
- While the strobe is high, the strobe counter steps down by one each cycle, so a command in mid-read cannot restart it.
- The bank output stays stable for the whole read.
- The first window word changes only on the cycle the strobe falls.
- The done flag is set when the strobe falls.
- A status write of zero clears the done flag unless a capture happens in the same cycle.

Only the bench scenarios can show the rest:
- The exact strobe length for random periods, including a period of zero.
- Byte-correct contents of all eight banks when addressed with junk bits.
- Register readback values.
- That writing a one to the done bit leaves the flag clear.

// File: rtl/otp_bank_reader.sv
module otp_bank_reader #(
  parameter int NUM_BANKS  = 8,
  parameter int WORDS      = 4,
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int DEF_PERIOD = 30
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [AW-1:0]                 bus_addr,
  input  logic [DW-1:0]                 bus_wdata,
  output logic [DW-1:0]                 bus_rdata,
  output logic                          fuse_rd,
  output logic [$clog2(NUM_BANKS)-1:0]  fuse_bank,
  input  logic [WORDS*DW-1:0]           fuse_data,
  output logic                          rd_done
);
  localparam int BW     = $clog2(NUM_BANKS);
  localparam int BIT_SH = $clog2(WORDS*DW);
  localparam logic [AW-1:0] OFF_WIN  = AW'(8'h20);
  localparam logic [AW-1:0] OFF_CTRL = AW'(8'h48);
  localparam logic [AW-1:0] OFF_STAT = AW'(8'h4C);
  localparam logic [AW-1:0] OFF_ADDR = AW'(8'h50);

  logic [7:0]    period, cnt;
  logic [4:0]    keep;
  logic          busy, done;
  logic [BW-1:0] addr_bank, bank;
  logic [DW-1:0] win [WORDS];

  wire wr_ctl = bus_wr && bus_addr == OFF_CTRL;
  wire wr_sta = bus_wr && bus_addr == OFF_STAT;
  wire wr_adr = bus_wr && bus_addr == OFF_ADDR;
  wire finish = busy && cnt == 8'd1;

  assign fuse_rd   = busy;
  assign fuse_bank = bank;
  assign rd_done   = done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period    <= 8'(DEF_PERIOD);
      keep      <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      addr_bank <= '0;
      bank      <= '0;
      for (int i = 0; i < WORDS; i++) win[i] <= '0;
    end else begin
      if (wr_ctl && !busy) begin
        period <= bus_wdata[15:8];
        keep   <= {bus_wdata[5:3], bus_wdata[1:0]};
        if (bus_wdata[2]) begin
          busy <= 1'b1;
          cnt  <= (bus_wdata[15:8] == 8'd0) ? 8'd1 : bus_wdata[15:8];
          bank <= addr_bank;
        end
      end
      if (wr_adr) addr_bank <= bus_wdata[BIT_SH +: BW];
      if (busy) cnt <= cnt - 8'd1;
      if (finish) begin
        busy <= 1'b0;
        for (int i = 0; i < WORDS; i++) win[i] <= fuse_data[i*DW +: DW];
      end
      if (finish) done <= 1'b1;
      else if (wr_sta) done <= done & bus_wdata[4];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CTRL)
      bus_rdata = DW'({period, 2'b00, keep[4:2], busy, keep[1:0]});
    else if (bus_addr == OFF_STAT)
      bus_rdata = DW'({done, 4'b0000});
    else if (bus_addr == OFF_ADDR)
      bus_rdata = DW'(addr_bank) << BIT_SH;
    else
      for (int i = 0; i < WORDS; i++)
        if (bus_addr == OFF_WIN + AW'(4*i)) bus_rdata = win[i];
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd && $past(fuse_rd) |-> cnt == $past(cnt) - 8'd1); // R6
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd && $past(fuse_rd) |-> $stable(fuse_bank)); // R3
  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_rd) |-> rd_done); // R4
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(fuse_rd) |-> $stable(win[0])); // R6
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sta && !bus_wdata[4] && !finish |=> !rd_done); // R7
endmodule

// File: tb/otp_bank_reader_tb.sv
`timescale 1ns/1ps
module otp_bank_reader_tb;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fuse_rd, rd_done;
  logic [2:0] fuse_bank;
  logic [127:0] fuse_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  otp_bank_reader u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_rd(fuse_rd), .fuse_bank(fuse_bank),
    .fuse_data(fuse_data), .rd_done(rd_done));

  function automatic logic [31:0] fw(int b, int n);
    return (32'h9E3779B9 * 32'(b*4 + n + 1)) ^ 32'hA5C3_0F1E;
  endfunction

  always_comb
    for (int n = 0; n < 4; n++) fuse_data[32*n +: 32] = fw(int'(fuse_bank), n);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic count_strobe(output int n);
    n = 0;
    while (fuse_rd) begin n++; @(negedge clk); end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, p, m;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobe", 32'(fuse_rd), 0);
    rd(8'h48, d); chk("R1 ctrl", d, 32'h1E00);
    rd(8'h4C, d); chk("R1 status", d, 0);
    rd(8'h50, d); chk("R1 addr", d, 0);
    for (int i = 0; i < 4; i++) begin rd(8'h20 + 8'(4*i), d); chk("R1 window", d, 0); end
    rd(8'h10, d); chk("R2 unmapped", d, 0);

    // R3 R4 R5: every bank, random periods and junk address bits
    for (int b = 0; b < 8; b++) begin
      p = 1 + int'($urandom % 40);
      wr(8'h4C, 0);
      wr(8'h50, 32'(b*128) | ($urandom & 32'h7F) | ($urandom << 10));
      rd(8'h50, d); chk("R5 addr readback", d, 32'(b*128));
      wr(8'h48, 32'(p << 8) | 32'h4);
      chk("R3 bank out", 32'(fuse_bank), 32'(b));
      rd(8'h48, d); chk("R4 busy bit", 32'(d[2]), 1);
      rd(8'h4C, d); chk("R4 done low mid-read", 32'(d[4]), 0);
      count_strobe(n); chk("R3 strobe length", 32'(n), 32'(p));
      rd(8'h4C, d); chk("R4 done set", d, 32'h10);
      chk("R4 done port", 32'(rd_done), 1);
      rd(8'h48, d); chk("R4 busy cleared", d, 32'(p << 8));
      for (int w = 0; w < 4; w++) begin
        rd(8'h20 + 8'(4*w), d);
        for (int k = 0; k < 4; k++)
          chk("R4 R2 window byte", 32'(d[8*k +: 8]), 32'(fw(b, w) >> (8*k)) & 32'hFF);
      end
    end

    // R7 done handshake
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, d); chk("R7 write one keeps done", d, 32'h10);
    wr(8'h4C, 32'hFFFF_FFEF);
    rd(8'h4C, d); chk("R7 clear done", d, 0);
    wr(8'h4C, 32'h10);
    rd(8'h4C, d); chk("R7 one does not set", d, 0);

    // R6 command during busy ignored, window held
    wr(8'h50, 32'(2*128));
    wr(8'h48, 32'h1404);
    rd(8'h20, d); chk("R6 window held", d, fw(7, 0));
    wr(8'h48, 32'h053F);
    chk("R6 bank held", 32'(fuse_bank), 2);
    count_strobe(n); chk("R6 strobe length", 32'(n + 2), 20);
    rd(8'h48, d); chk("R6 period unchanged", d, 32'h1400);
    rd(8'h20, d); chk("R6 new capture", d, fw(2, 0));

    // R8 period zero
    wr(8'h50, 32'(5*128));
    wr(8'h48, 32'h0004);
    count_strobe(n); chk("R8 one-cycle strobe", 32'(n), 1);
    rd(8'h2C, d); chk("R8 capture", d, fw(5, 3));

    // R9 stored bits, no start
    wr(8'h4C, 0);
    wr(8'h48, 32'h1E3B);
    m = 0;
    repeat (5) begin if (fuse_rd) m++; @(negedge clk); end
    chk("R9 no strobe", 32'(m), 0);
    rd(8'h48, d); chk("R9 readback", d, 32'h1E3B);
    rd(8'h4C, d); chk("R9 no done", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule